// File: doc/BRIEF.md
# I2C Target Byte Front End with High-Speed Entry

This block is the byte-level receive front end of an I2C target. It synchronises the oversampled SCL and SDA lines into the system clock domain and detects START, repeated START and STOP conditions from them. It shifts incoming bytes in and pulls SDA low during the acknowledge slot when a byte is to be accepted. Accepted address and write-data bytes are handed to downstream logic as a one-cycle byte strobe, together with a first-byte flag and a direction flag. The block has no transmit data path and no clock stretching, and no analog spike filtering is done here.

The block also handles two bus-wide protocol features. The first is the high-speed master code: a first byte of the form `00001xxx` is left unacknowledged and raises a mode flag. That flag can steer input filter selection elsewhere. It survives any number of repeated STARTs and drops at the next STOP. The second is a general-call reset sequence. The block acknowledges the general-call address `0x00` and then a data byte `0x06`, and afterwards pulses a reset request. Any other general-call data byte is refused.

Top module: `i2c_hs_target`

## Requirements
- R1: While reset is held and right after it is released, `sda_oe_o`, `hs_mode_o`, `gc_reset_o` and `byte_valid_o` are all 0.
- R2: A first byte after START whose bits 7:1 equal `DEV_ADDR` is acknowledged (SDA held low for the ninth clock). It is strobed once on `byte_valid_o` with `byte_first_o`=1, `byte_data_o` equal to the byte, and `byte_read_o` equal to bit 0, where 0 means write and 1 means read.
- R3: A first byte that is not the device address, not `0x00` and not of the form `00001xxx` is not acknowledged and is not strobed. Every further byte, even `0x00`, is ignored until the next START or STOP.
- R4: After an acknowledged write address, each following byte is acknowledged and strobed with `byte_first_o`=0, `byte_read_o`=0 and its value on `byte_data_o`.
- R5: After an acknowledged read address, the block leaves SDA released for all later clocks of that transfer and produces no strobe.
- R6: A first byte matching `00001xxx` (any low three bits) is not acknowledged and not strobed. `hs_mode_o` is 1 by the end of that byte's ninth clock.
- R7: Once set, `hs_mode_o` stays 1 through any number of repeated STARTs and returns to 0 at the next STOP or at reset.
- R8: The general-call address byte `0x00` is always acknowledged and never strobed.
- R9: After a general-call address, a data byte `0x06` is acknowledged, and `gc_reset_o` pulses for exactly one cycle after the falling edge that ends its ninth clock. Any other data byte there is not acknowledged and gives no pulse.
- R10: START (SDA falling while SCL high) and STOP (SDA rising while SCL high) are seen on the synchronised lines. A START at any point restarts address reception. `sda_oe_o` only changes while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| hs_mode_o | output | 1 | High-speed mode active |
| gc_reset_o | output | 1 | One-cycle general-call reset request |
| byte_valid_o | output | 1 | One-cycle strobe for an accepted byte |
| byte_data_o | output | 8 | Value of the strobed byte |
| byte_first_o | output | 1 | Strobed byte is the address byte |
| byte_read_o | output | 1 | Direction bit of the current transfer |

## Verification
The assertions assume a well-behaved controller. SDA changes only while SCL is low, except where it forms a START or STOP, and no START or STOP is issued while the target holds SDA low in an acknowledge slot. Each SCL phase also lasts longer than the synchroniser and edge-detect delay. The bench model drives every data bit and the released acknowledge bit with SCL low. It generates START, repeated START and STOP with SCL high and the target released, and holds each quarter bit for several system clocks.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;

  localparam logic [BYTE_W-1:0] GCALL_ADDR_BYTE = 8'h00;
  localparam logic [BYTE_W-1:0] GCALL_RESET_CODE = 8'h06;
  localparam logic [4:0]        HS_CODE_PREFIX = 5'b00001;

  // transfer context: what the byte being shifted means
  typedef enum logic [2:0] {
    CTX_IDLE,
    CTX_ADDR,
    CTX_WDATA,
    CTX_GCDATA,
    CTX_SKIP
  } ctx_e;

  // classification of a first byte after START
  typedef enum logic [1:0] {
    FB_OTHER,
    FB_MATCH,
    FB_GCALL,
    FB_HSCODE
  } fb_class_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // bus lines idle high, so the chain resets to all ones
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_prev_q;
  logic sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  // SCL held high across both samples qualifies an SDA transition
  assign start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
  assign scl_rise_o = scl_s & ~scl_prev_q;
  assign scl_fall_o = ~scl_s & scl_prev_q;
endmodule

// File: rtl/i2c_bit_shifter.sv
module i2c_bit_shifter #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic            scl_rise_i,
  input  logic            sda_s,
  output logic [BITS-1:0] data_o,
  output logic            full_o
);
  localparam int unsigned CNT_W = $clog2(BITS + 1);

  logic [BITS-1:0]  shreg_q, shreg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign full_o = (cnt_q == CNT_W'(BITS));

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i && scl_rise_i && !full_o) begin
      shreg_d = {shreg_q[BITS-2:0], sda_s};
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
    end
  end

  assign data_o = shreg_q;
endmodule

// File: rtl/i2c_first_byte_decode.sv
module i2c_first_byte_decode
  import i2c_hs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2C
) (
  input  logic [BYTE_W-1:0] byte_i,
  output fb_class_e         class_o
);
  // master code check first: its low bit is not a direction flag
  always_comb begin
    if (byte_i[BYTE_W-1:3] == HS_CODE_PREFIX)  class_o = FB_HSCODE;
    else if (byte_i == GCALL_ADDR_BYTE)        class_o = FB_GCALL;
    else if (byte_i[BYTE_W-1:1] == DEV_ADDR)   class_o = FB_MATCH;
    else                                       class_o = FB_OTHER;
  end
endmodule

// File: rtl/i2c_hs_target.sv
module i2c_hs_target
  import i2c_hs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h2C,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              hs_mode_o,
  output logic              gc_reset_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic              byte_first_o,
  output logic              byte_read_o
);
  logic [1:0]        sync_bus;
  logic              scl_s, sda_s;
  logic              start_det, stop_det, scl_rise, scl_fall;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_full;
  logic              shift_clr, shift_en;
  fb_class_e         fb_class;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({scl_i, sda_i}),
    .sync_o  (sync_bus)
  );
  assign scl_s = sync_bus[1];
  assign sda_s = sync_bus[0];

  i2c_cond_detect u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .start_o    (start_det),
    .stop_o     (stop_det),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  i2c_bit_shifter #(.BITS(BYTE_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (shift_clr),
    .en_i       (shift_en),
    .scl_rise_i (scl_rise),
    .sda_s      (sda_s),
    .data_o     (rx_byte),
    .full_o     (rx_full)
  );

  i2c_first_byte_decode #(.DEV_ADDR(DEV_ADDR)) u_decode (
    .byte_i  (rx_byte),
    .class_o (fb_class)
  );

  // state registers
  ctx_e              ctx_q, ctx_d;
  ctx_e              post_q, post_d;
  logic              ackph_q, ackph_d;
  logic              oe_q, oe_d;
  logic              hs_q, hs_d;
  logic              gcpend_q, gcpend_d;
  logic              gcpulse_q, gcpulse_d;
  logic              valid_q, valid_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              first_q, first_d;
  logic              read_q, read_d;
  logic              byte_done;
  logic              rx_ctx;

  assign rx_ctx    = (ctx_q == CTX_ADDR) || (ctx_q == CTX_WDATA) || (ctx_q == CTX_GCDATA);
  assign shift_en  = rx_ctx && !ackph_q;
  assign byte_done = shift_en && rx_full && scl_fall;

  always_comb begin
    ctx_d     = ctx_q;
    post_d    = post_q;
    ackph_d   = ackph_q;
    oe_d      = oe_q;
    hs_d      = hs_q;
    gcpend_d  = gcpend_q;
    gcpulse_d = 1'b0;
    valid_d   = 1'b0;
    data_d    = data_q;
    first_d   = first_q;
    read_d    = read_q;
    shift_clr = 1'b0;

    if (stop_det) begin
      ctx_d     = CTX_IDLE;
      ackph_d   = 1'b0;
      oe_d      = 1'b0;
      hs_d      = 1'b0;
      gcpend_d  = 1'b0;
      shift_clr = 1'b1;
    end else if (start_det) begin
      ctx_d     = CTX_ADDR;
      ackph_d   = 1'b0;
      oe_d      = 1'b0;
      gcpend_d  = 1'b0;
      shift_clr = 1'b1;
    end else if (ackph_q) begin
      // the falling edge after the ninth clock closes the ACK slot
      if (scl_fall) begin
        ackph_d   = 1'b0;
        oe_d      = 1'b0;
        ctx_d     = post_q;
        shift_clr = 1'b1;
        gcpulse_d = gcpend_q;
        gcpend_d  = 1'b0;
      end
    end else if (byte_done) begin
      unique case (ctx_q)
        CTX_ADDR: begin
          unique case (fb_class)
            FB_MATCH: begin
              valid_d = 1'b1;
              first_d = 1'b1;
              read_d  = rx_byte[0];
              data_d  = rx_byte;
              ackph_d = 1'b1;
              oe_d    = 1'b1;
              post_d  = rx_byte[0] ? CTX_SKIP : CTX_WDATA;
            end
            FB_GCALL: begin
              ackph_d = 1'b1;
              oe_d    = 1'b1;
              post_d  = CTX_GCDATA;
            end
            FB_HSCODE: begin
              hs_d  = 1'b1;
              ctx_d = CTX_SKIP;
            end
            default: ctx_d = CTX_SKIP;
          endcase
        end
        CTX_WDATA: begin
          valid_d = 1'b1;
          first_d = 1'b0;
          read_d  = 1'b0;
          data_d  = rx_byte;
          ackph_d = 1'b1;
          oe_d    = 1'b1;
          post_d  = CTX_WDATA;
        end
        CTX_GCDATA: begin
          if (rx_byte == GCALL_RESET_CODE) begin
            ackph_d  = 1'b1;
            oe_d     = 1'b1;
            gcpend_d = 1'b1;
            post_d   = CTX_SKIP;
          end else begin
            ctx_d = CTX_SKIP;
          end
        end
        default: ctx_d = CTX_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q     <= CTX_IDLE;
      post_q    <= CTX_IDLE;
      ackph_q   <= 1'b0;
      oe_q      <= 1'b0;
      hs_q      <= 1'b0;
      gcpend_q  <= 1'b0;
      gcpulse_q <= 1'b0;
      valid_q   <= 1'b0;
      data_q    <= '0;
      first_q   <= 1'b0;
      read_q    <= 1'b0;
    end else begin
      ctx_q     <= ctx_d;
      post_q    <= post_d;
      ackph_q   <= ackph_d;
      oe_q      <= oe_d;
      hs_q      <= hs_d;
      gcpend_q  <= gcpend_d;
      gcpulse_q <= gcpulse_d;
      valid_q   <= valid_d;
      data_q    <= data_d;
      first_q   <= first_d;
      read_q    <= read_d;
    end
  end

  assign sda_oe_o     = oe_q;
  assign hs_mode_o    = hs_q;
  assign gc_reset_o   = gcpulse_q;
  assign byte_valid_o = valid_q;
  assign byte_data_o  = data_q;
  assign byte_first_o = first_q;
  assign byte_read_o  = read_q;
endmodule

// File: rtl/i2c_hs_target_chk.sv
module i2c_hs_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe_o,
  input logic hs_mode_o,
  input logic gc_reset_o,
  input logic byte_valid_o
);
  // outputs are quiet while reset is applied
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!sda_oe_o && !hs_mode_o && !gc_reset_o && !byte_valid_o);
    end
  end

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |=> !byte_valid_o);

  assert_hs_hold_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && hs_mode_o) |=> hs_mode_o);

  assert_hs_clear_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs_mode_o);

  assert_gc_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset_o |=> !gc_reset_o);

  assert_gc_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset_o |-> !byte_valid_o);

  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s);
endmodule

bind i2c_hs_target i2c_hs_target_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_s        (scl_s),
  .start_det    (start_det),
  .stop_det     (stop_det),
  .sda_oe_o     (sda_oe_o),
  .hs_mode_o    (hs_mode_o),
  .gc_reset_o   (gc_reset_o),
  .byte_valid_o (byte_valid_o)
);

// File: tb/i2c_hs_target_bench.sv
module i2c_hs_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 4;
  localparam logic [6:0] DEV = 7'h2C;

  logic clk, rst_n;
  logic scl_m, sda_m;
  logic sda_oe, hs_mode, gc_reset, bvalid, bfirst, bread;
  logic [7:0] bdata;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int strobe_cnt = 0;
  int gc_cnt = 0;
  int oe_cnt = 0;
  logic [7:0] last_data;
  logic last_first, last_read;
  logic last_ack;
  int gc_at_ack;
  bit done = 0;

  i2c_hs_target #(.DEV_ADDR(DEV), .SYNC_STAGES(2)) u_i2c_hs_target (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_bus),
    .sda_oe_o     (sda_oe),
    .hs_mode_o    (hs_mode),
    .gc_reset_o   (gc_reset),
    .byte_valid_o (bvalid),
    .byte_data_o  (bdata),
    .byte_first_o (bfirst),
    .byte_read_o  (bread)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor sampled on the inactive edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (bvalid) begin
        strobe_cnt++;
        last_data  = bdata;
        last_first = bfirst;
        last_read  = bread;
      end
      if (gc_reset) gc_cnt++;
      if (sda_oe) oe_cnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(1);
      scl_m = 1'b1; wq(2);
      scl_m = 1'b0; wq(1);
    end
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    last_ack  = ~sda_bus;
    gc_at_ack = gc_cnt;
    wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 oe in reset", int'(sda_oe), 0);
    chk("R1 hs in reset", int'(hs_mode), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 oe after reset", int'(sda_oe), 0);
    chk("R1 hs after reset", int'(hs_mode), 0);
    chk("R1 strobe after reset", int'(bvalid), 0);
    chk("R1 gc after reset", int'(gc_reset), 0);

    // sweep of every first byte: R2, R3, R6, R8
    for (int b = 0; b < 256; b++) begin
      int s0;
      bit is_hs, is_gc, is_dev;
      logic [7:0] bb;
      bb = 8'(b);
      is_hs  = (bb[7:3] == 5'b00001);
      is_gc  = (bb == 8'h00);
      is_dev = !is_hs && (bb[7:1] == DEV);
      s0 = strobe_cnt;
      bus_start();
      send_byte(bb);
      chk("R2 R3 R6 R8 first-byte ack", int'(last_ack), int'(is_dev || is_gc));
      chk("R2 R3 R6 R8 strobe count", strobe_cnt - s0, int'(is_dev));
      if (is_dev) begin
        chk("R2 data", int'(last_data), b);
        chk("R2 first flag", int'(last_first), 1);
        chk("R2 direction", int'(last_read), int'(bb[0]));
      end
      chk("R6 hs after master code", int'(hs_mode), int'(is_hs));
      bus_stop();
      chk("R7 hs cleared at stop", int'(hs_mode), 0);
    end

    // R3: after a mismatch even 0x00 is ignored
    begin
      int s0;
      s0 = strobe_cnt;
      bus_start();
      send_byte(8'hA4);
      send_byte(8'h00);
      chk("R3 byte after mismatch ack", int'(last_ack), 0);
      send_byte({DEV, 1'b0});
      chk("R3 own address after mismatch ack", int'(last_ack), 0);
      chk("R3 no strobes", strobe_cnt - s0, 0);
      bus_stop();
    end

    // R4: write data sweep in one transfer
    begin
      int s0;
      bus_start();
      send_byte({DEV, 1'b0});
      for (int d = 0; d < 256; d++) begin
        s0 = strobe_cnt;
        send_byte(8'(d));
        chk("R4 data ack", int'(last_ack), 1);
        chk("R4 strobe", strobe_cnt - s0, 1);
        chk("R4 data value", int'(last_data), d);
        chk("R4 first flag", int'(last_first), 0);
        chk("R4 direction", int'(last_read), 0);
      end
      bus_stop();
    end

    // R5: read address, then SDA never driven
    begin
      int s0, o0;
      bus_start();
      send_byte({DEV, 1'b1});
      chk("R5 read address ack", int'(last_ack), 1);
      s0 = strobe_cnt; o0 = oe_cnt;
      send_byte(8'hFF);
      send_byte(8'h00);
      chk("R5 no SDA drive", oe_cnt - o0, 0);
      chk("R5 no strobe", strobe_cnt - s0, 0);
      bus_stop();
    end

    // R7, R10: hs mode across repeated STARTs, START restarts addressing
    begin
      int s0;
      bus_start();
      send_byte(8'h0D);
      chk("R6 master code nack", int'(last_ack), 0);
      chk("R6 hs set", int'(hs_mode), 1);
      bus_rstart();
      chk("R7 hs after rstart", int'(hs_mode), 1);
      s0 = strobe_cnt;
      send_byte({DEV, 1'b0});
      chk("R10 address after rstart ack", int'(last_ack), 1);
      send_byte(8'h5A);
      chk("R7 hs during data", int'(hs_mode), 1);
      bus_rstart();
      send_byte(8'h33);
      chk("R10 rstart mid-transfer restarts addressing", int'(last_ack), 0);
      bus_rstart();
      send_byte({DEV, 1'b0});
      chk("R10 second rstart ack", int'(last_ack), 1);
      chk("R10 strobes", strobe_cnt - s0, 3);
      chk("R7 hs after second rstart", int'(hs_mode), 1);
      bus_stop();
      chk("R7 hs cleared", int'(hs_mode), 0);
    end

    // R9: general-call data sweep
    for (int d = 0; d < 20; d++) begin
      int g0, s0;
      logic [7:0] dv;
      dv = (d < 16) ? 8'(d) : (d == 16 ? 8'h86 : (d == 17 ? 8'h60 : (d == 18 ? 8'hFF : 8'h07)));
      g0 = gc_cnt; s0 = strobe_cnt;
      bus_start();
      send_byte(8'h00);
      chk("R8 gc address ack", int'(last_ack), 1);
      send_byte(dv);
      chk("R9 gc data ack", int'(last_ack), int'(dv == 8'h06));
      chk("R9 no pulse before ack ends", gc_at_ack - g0, 0);
      chk("R9 pulse count", gc_cnt - g0, int'(dv == 8'h06));
      chk("R8 gc never strobed", strobe_cnt - s0, 0);
      send_byte(8'h06);
      chk("R9 later byte ignored", gc_cnt - g0, int'(dv == 8'h06));
      bus_stop();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule